// File: doc/BRIEF.md
# Serial Control Channel Register Access Handler

This block sits behind the receive side of a byte-oriented serial control channel and turns incoming messages into register accesses. Bytes arrive one at a time, already validated by the neighbouring handshake logic, and pair up as an address byte followed by a data byte. One message may hold several such pairs. An end-of-message strobe closes the message. A pair that is still half-received at that point is thrown away.

The address byte carries a seven-bit register number in bits 7..1 and a direction flag in bit 0. A flag of 0 stores the data byte into an internal file of 128 eight-bit registers. A flag of 1 asks for a read-back: the data byte is discarded and a reply pair is queued. Other logic may also post spontaneous interrupt reports. Both kinds of outgoing pair wait in a small queue in arrival order, and a transmit engine takes them over a valid/ready handshake. In an outgoing address byte, bit 0 set marks a read-back reply and bit 0 clear marks a spontaneous report.

Top module: `mon_regif`

## Requirements
- R1: After a synchronous reset, every register reads back as 0x00, `tx_valid` is low and `ovf_flag` is low.
- R2: An address byte with bit 0 = 0, followed by a data byte, loads the data byte into the register numbered by address bits 7..1.
- R3: An address byte with bit 0 = 1, followed by any data byte, queues a reply whose address byte is the same register number in bits 7..1 with bit 0 = 1, and whose data byte is that register's current content. The incoming data byte leaves the register unchanged.
- R4: Several address/data pairs in one message are each carried out in the order received, writes and read-backs mixed.
- R5: An end-of-message strobe that arrives after an odd number of bytes discards the pending address byte with no write and no reply, and the next byte is taken as a fresh address byte.
- R6: A pulse on `irq_valid` queues a report whose address byte is `irq_addr` in bits 7..1 with bit 0 = 0, and whose data byte is `irq_data`.
- R7: Outgoing pairs leave in arrival order. A read-back counts as arriving on the cycle of its data byte, and a report counts as arriving on the cycle of `irq_valid`. When both arrive in the same cycle, the read-back reply goes first.
- R8: The queue holds 4 pairs. A pair that arrives while it is full is dropped and sets `ovf_flag`, which stays set until reset.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_addr_byte` and `tx_data_byte` hold their values. A pair is removed only on a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | One validated received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_eom | input | 1 | End of the current received message |
| irq_valid | input | 1 | Post a spontaneous report |
| irq_addr | input | 7 | Register number carried by the report |
| irq_data | input | 8 | Data carried by the report |
| tx_ready | input | 1 | Transmit engine accepts the offered pair |
| tx_valid | output | 1 | An outgoing pair is offered |
| tx_addr_byte | output | 8 | Outgoing first byte: register number and reply/report flag |
| tx_data_byte | output | 8 | Outgoing second byte |
| ovf_flag | output | 1 | Sticky queue overflow indication |

## Verification
The checks assume that `rx_eom` never shares a cycle with `rx_valid`, and that the transmit engine keeps `tx_ready` free of combinational dependence on `tx_valid`. The stimulus leaves at least one idle cycle between bytes and strobes the end of message on a byte-free cycle. Reply ordering is checked by issuing a read-back data byte and an interrupt request on the same edge. The queue is filled with `tx_ready` held low, both to force a drop and to watch the held pair stay stable.

// File: rtl/mon_pkg.sv
package mon_pkg;
  localparam int MON_AW = 7;   // register number width
  localparam int MON_DW = 8;   // register data width

  // one outgoing address/data pair
  typedef struct packed {
    logic [MON_AW-1:0] addr;
    logic              rb;     // 1: read-back reply, 0: spontaneous report
    logic [MON_DW-1:0] data;
  } mon_pair_t;

  localparam int PAIR_W = $bits(mon_pair_t);
endpackage

// File: rtl/mon_decode.sv
// Pairs validated bytes into address/data cycles and issues accesses.
module mon_decode #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_eom,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] wr_data
);
  logic          have_addr;
  logic [AW-1:0] addr_q;
  logic          rb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_addr <= 1'b0;
      addr_q    <= '0;
      rb_q      <= 1'b0;
    end else if (rx_eom) begin
      // dangling address byte is dropped
      have_addr <= 1'b0;
    end else if (rx_valid) begin
      if (!have_addr) begin
        addr_q    <= rx_byte[DW-1 -: AW];
        rb_q      <= rx_byte[0];
        have_addr <= 1'b1;
      end else begin
        have_addr <= 1'b0;
      end
    end
  end

  always_comb begin
    wr_en    = rx_valid && !rx_eom && have_addr && !rb_q;
    rd_en    = rx_valid && !rx_eom && have_addr &&  rb_q;
    acc_addr = addr_q;
    wr_data  = rx_byte;
  end
endmodule

// File: rtl/mon_regfile.sv
// Register file with one shared port: write or registered read.
module mon_regfile #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rvalid,
  output logic [AW-1:0] rtag,
  output logic [DW-1:0] rdata
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rtag   <= '0;
      rdata  <= '0;
    end else begin
      rvalid <= re;
      if (re) begin
        rtag  <= addr;
        rdata <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/mon_fifo.sv
// Reply queue with two ordered push ports (a before b) and one pop port.
// DEPTH is expected to be a power of two so pointers wrap naturally.
module mon_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_a,
  input  logic [W-1:0]  data_a,
  input  logic          push_b,
  input  logic [W-1:0]  data_b,
  input  logic          pop,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [LW-1:0] level,
  output logic          ovf
);
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wptr, rptr, wslot_b;
  logic [LW-1:0] room, n_in;
  logic          acc_a, acc_b, take;

  always_comb begin
    room    = LW'(DEPTH) - level;
    acc_a   = push_a && (room != '0);
    acc_b   = push_b && (room > (acc_a ? LW'(1) : LW'(0)));
    n_in    = LW'(acc_a) + LW'(acc_b);
    wslot_b = wptr + PW'(acc_a);
    take    = pop && (level != '0);
  end

  always_ff @(posedge clk) begin
    if (acc_a) slots[wptr]    <= data_a;
    if (acc_b) slots[wslot_b] <= data_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      wptr  <= wptr + PW'(n_in);
      rptr  <= rptr + PW'(take);
      level <= level + n_in - LW'(take);
      if ((push_a && !acc_a) || (push_b && !acc_b)) ovf <= 1'b1;
    end
  end

  assign out_valid = (level != '0);
  assign out_data  = slots[rptr];
endmodule

// File: rtl/mon_regif.sv
module mon_regif
  import mon_pkg::*;
#(
  parameter int AW      = MON_AW,
  parameter int DW      = MON_DW,
  parameter int Q_DEPTH = 4,
  localparam int LVL_W  = $clog2(Q_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_eom,
  input  logic          irq_valid,
  input  logic [AW-1:0] irq_addr,
  input  logic [DW-1:0] irq_data,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_addr_byte,
  output logic [DW-1:0] tx_data_byte,
  output logic          ovf_flag
);
  localparam int PW = AW + 1 + DW;

  logic          wr_en, rd_en;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] wr_data;
  logic          rd_vld;
  logic [AW-1:0] rd_tag;
  logic [DW-1:0] rd_data;
  logic          irq_v_q;
  logic [AW-1:0] irq_a_q;
  logic [DW-1:0] irq_d_q;
  logic [PW-1:0] pair_rb, pair_irq, pair_out;
  logic [LVL_W-1:0] q_level;

  mon_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_eom(rx_eom), .wr_en(wr_en), .rd_en(rd_en),
    .acc_addr(acc_addr), .wr_data(wr_data)
  );

  mon_regfile #(.AW(AW), .DW(DW)) u_rf (
    .clk(clk), .rst(rst), .we(wr_en), .re(rd_en), .addr(acc_addr),
    .wdata(wr_data), .rvalid(rd_vld), .rtag(rd_tag), .rdata(rd_data)
  );

  // reports take one stage so they line up with the read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_v_q <= 1'b0;
      irq_a_q <= '0;
      irq_d_q <= '0;
    end else begin
      irq_v_q <= irq_valid;
      irq_a_q <= irq_addr;
      irq_d_q <= irq_data;
    end
  end

  assign pair_rb  = {rd_tag,  1'b1, rd_data};
  assign pair_irq = {irq_a_q, 1'b0, irq_d_q};

  mon_fifo #(.W(PW), .DEPTH(Q_DEPTH)) u_q (
    .clk(clk), .rst(rst),
    .push_a(rd_vld), .data_a(pair_rb),
    .push_b(irq_v_q), .data_b(pair_irq),
    .pop(tx_ready), .out_valid(tx_valid), .out_data(pair_out),
    .level(q_level), .ovf(ovf_flag)
  );

  assign tx_addr_byte = pair_out[PW-1 -: DW];
  assign tx_data_byte = pair_out[DW-1:0];
endmodule

// File: rtl/mon_regif_chk.sv
module mon_regif_chk #(
  parameter int DEPTH = 4,
  parameter int LW    = 3,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_addr_byte,
  input logic [DW-1:0] tx_data_byte,
  input logic          ovf_flag,
  input logic [LW-1:0] q_level
);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_addr_byte) && $stable(tx_data_byte)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(q_level) >= LW'(DEPTH - 1)));

  // R8
  level_cap_chk: assert property (@(posedge clk) disable iff (rst)
    q_level <= LW'(DEPTH));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_valid && !ovf_flag));
endmodule

bind mon_regif mon_regif_chk #(.DEPTH(Q_DEPTH), .LW(LVL_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_addr_byte(tx_addr_byte), .tx_data_byte(tx_data_byte),
  .ovf_flag(ovf_flag), .q_level(q_level)
);

// File: tb/sim_mon_regif.sv
`timescale 1ns/1ps
module sim_mon_regif;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_eom = 1'b0;
  logic       irq_valid = 1'b0;
  logic [6:0] irq_addr = '0;
  logic [7:0] irq_data = '0;
  logic       tx_ready = 1'b1;
  logic       tx_valid;
  logic [7:0] tx_addr_byte, tx_data_byte;
  logic       ovf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  model [128];

  always #10 clk = ~clk;   // 50 MHz

  mon_regif u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_eom(rx_eom), .irq_valid(irq_valid), .irq_addr(irq_addr),
    .irq_data(irq_data), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_addr_byte(tx_addr_byte), .tx_data_byte(tx_data_byte),
    .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_pair(input string req, input logic [6:0] a, input logic rb, input logic [7:0] d);
    exp_q.push_back({a, rb, d});
    tag_q.push_back(req);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_eom();
    @(negedge clk); rx_eom = 1'b1;
    @(negedge clk); rx_eom = 1'b0;
  endtask

  task automatic do_write(input string req, input logic [6:0] a, input logic [7:0] d);
    send_byte({a, 1'b0});
    send_byte(d);
    model[a] = d;
  endtask

  task automatic do_read(input string req, input logic [6:0] a, input logic [7:0] junk);
    send_byte({a, 1'b1});
    expect_pair(req, a, 1'b1, model[a]);
    send_byte(junk);
  endtask

  task automatic post_irq(input string req, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); irq_valid = 1'b1; irq_addr = a; irq_data = d;
    expect_pair(req, a, 1'b0, d);
    @(negedge clk); irq_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
  endtask

  // monitor: compares each accepted pair with the scoreboard head
  initial begin
    forever begin
      @(negedge clk); #5;
      if (!rst && tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check("R4 unexpected pair", {tx_addr_byte, tx_data_byte}, 16'hxxxx);
        end else begin
          check(tag_q.pop_front(), {tx_addr_byte, tx_data_byte}, exp_q.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held_a, held_d;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
    check("R1 ovf_flag", {15'd0, ovf_flag}, 16'd0);
    do_read("R1 reg7F after reset", 7'h7F, 8'hAA);
    do_read("R1 reg00 after reset", 7'h00, 8'h55);
    drain();

    // R2 / R3 writes and read-backs
    do_write("R2", 7'h12, 8'hC3);
    do_read("R2 readback 12", 7'h12, 8'h00);
    do_read("R3 data byte ignored", 7'h12, 8'hFF);
    do_write("R2", 7'h7F, 8'h81);
    do_read("R3 readback 7F", 7'h7F, 8'h3C);
    send_eom();
    drain();

    // R4 mixed cycles within one message
    do_write("R4", 7'h01, 8'h11);
    do_write("R4", 7'h02, 8'h22);
    do_read("R4 read 01", 7'h01, 8'h00);
    do_write("R4", 7'h01, 8'h99);
    do_read("R4 read 01 updated", 7'h01, 8'h00);
    do_read("R4 read 02", 7'h02, 8'h00);
    send_eom();
    drain();

    // R5 odd byte count then end of message
    send_byte({7'h05, 1'b0});
    send_eom();
    do_read("R5 next byte is address", 7'h06, 8'h77);
    send_eom();
    do_read("R5 reg05 untouched", 7'h05, 8'h00);
    send_eom();
    drain();

    // R6 spontaneous report
    post_irq("R6 report", 7'h40, 8'h5A);
    drain();

    // R7 read-back data byte and report in the same cycle
    send_byte({7'h12, 1'b1});
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h00;
    irq_valid = 1'b1; irq_addr = 7'h33; irq_data = 8'hE1;
    expect_pair("R7 readback first", 7'h12, 1'b1, model[7'h12]);
    expect_pair("R7 report second", 7'h33, 1'b0, 8'hE1);
    @(negedge clk);
    rx_valid = 1'b0; irq_valid = 1'b0;
    post_irq("R7 later report", 7'h34, 8'hE2);
    send_eom();
    drain();

    // R8 / R9 fill the queue with the consumer stalled
    check("R8 flag clear before fill", {15'd0, ovf_flag}, 16'd0);
    @(negedge clk); tx_ready = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      irq_valid = 1'b1; irq_addr = 7'(8'h50 + k); irq_data = 8'(8'hA0 + k);
      if (k < 4) expect_pair("R8 kept entry", 7'(8'h50 + k), 1'b0, 8'(8'hA0 + k));
    end
    @(negedge clk); irq_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 overflow flag set", {15'd0, ovf_flag}, 16'd1);
    check("R9 valid while stalled", {15'd0, tx_valid}, 16'd1);
    held_a = tx_addr_byte; held_d = tx_data_byte;
    repeat (3) @(negedge clk);
    check("R9 pair held", {tx_addr_byte, tx_data_byte}, {held_a, held_d});
    tx_ready = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    check("R8 flag sticky", {15'd0, ovf_flag}, 16'd1);
    check("R8 fifth entry dropped", {15'd0, tx_valid}, 16'd0);
    check("R4 scoreboard empty", 16'(exp_q.size()), 16'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule